// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block places one test cell on every signal crossing between the core logic and the device pins. Input cells sit on the pin-to-core path and output cells sit on the core-to-pin path. While test mode is off, every cell is transparent and the core and pins see each other directly. While test mode is on, each cell drives its side from a held update latch instead, so the chain can apply a fixed stimulus to the board or to the core.

All cells are linked into one serial register between the scan input and the scan output. A test access port controller supplies the capture, shift and update strobes, the test mode select, and the test-logic reset. A capture strobe samples the parallel values seen by every cell. Shift strobes move that snapshot out one bit per clock while new data moves in behind it. An update strobe then copies the new data into the held latches in a single step. Because shifting and holding use separate storage, the driven values stay steady for the whole time data moves through the chain.

Top module: `bscan_chain`

## Requirements
- R1: With `test_mode` low, `core_in` equals `pin_in` and `pin_out` equals `core_out` in the same cycle, whatever the latches hold.
- R2: With `test_mode` high, `core_in` shows update latch bits [N_IN-1:0] and `pin_out` shows update latch bits [N_IN+N_OUT-1:N_IN].
- R3: A clock edge with `capture` high loads the shift stages with the concatenation {`core_out`, `pin_in`}, with `pin_in[0]` in stage 0.
- R4: A clock edge with `shift` high and `capture` low moves every stage one place toward stage 0, and `tdi` enters the top stage (N_IN+N_OUT-1).
- R5: `tdo` always presents stage 0, so the bit in stage 0 leaves the chain first. After N_IN+N_OUT shifts, the first `tdi` bit has reached stage 0.
- R6: The update latches change only on a clock edge with `update` high, and they then take the values the shift stages held before that edge.
- R7: While `rst_n` is low, all shift stages and all update latches are 0. In test mode, `pin_out`, `core_in` and `tdo` therefore read 0.
- R8: When `capture` and `shift` are high on the same edge, capture wins and the stages take the parallel values.
- R9: On an edge with neither `capture` nor `shift` high, the shift stages keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous test-logic reset, active low |
| test_mode | input | 1 | High: cells drive their sides from the update latches |
| capture | input | 1 | Load parallel cell values into the shift stages |
| shift | input | 1 | Shift the chain one place toward `tdo` |
| update | input | 1 | Copy the shift stages into the update latches |
| tdi | input | 1 | Serial data into the top stage |
| tdo | output | 1 | Serial data out of stage 0 |
| pin_in | input | N_IN | Values arriving at input pins |
| core_in | output | N_IN | Values handed to the core from the input cells |
| core_out | input | N_OUT | Values the core drives toward output pins |
| pin_out | output | N_OUT | Values driven onto the output pins |

## Verification
The hardest case to reach from the ports is the one where the held outputs and the moving shift stages differ while shifting is under way. Checking it needs a known pattern already in the update latches and a different pattern passing through the chain. The stimulus first loads and updates one pattern. It then captures fresh pin values and shifts a second pattern through, checking `pin_out` and `core_in` after every single shift. Only after that does it issue the update and confirm that the second pattern appears all at once.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out
);
  localparam int N = N_IN + N_OUT;

  logic [N-1:0] stage_q;
  logic [N-1:0] latch_q;
  logic [N-1:0] par_in;

  assign par_in = {core_out, pin_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage_q <= '0;
    else if (capture) stage_q <= par_in;
    else if (shift)   stage_q <= {tdi, stage_q[N-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= '0;
    else if (update) latch_q <= stage_q;
  end

  assign tdo     = stage_q[0];
  assign core_in = test_mode ? latch_q[N_IN-1:0] : pin_in;
  assign pin_out = test_mode ? latch_q[N-1:N_IN] : core_out;

  a_r3_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> stage_q == $past(par_in));

  a_r4_tdi_enters_top: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture) |=> stage_q[N-1] == $past(tdi));

  a_r5_tdo_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture) |=> tdo == $past(stage_q[1]));

  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(latch_q));

  a_r6_latch_takes_stage: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> latch_q == $past(stage_q));

  a_r9_stage_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !shift) |=> $stable(stage_q));

  always_comb begin
    if (!rst_n) a_r7_reset_clear: assert (stage_q == '0 || $isunknown(stage_q));
  end
endmodule

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int N  = NI + NO;

  logic clk = 0, rst_n = 0, test_mode = 0, capture = 0, shift = 0, update = 0, tdi = 0;
  logic tdo;
  logic [NI-1:0] pin_in = '0, core_in;
  logic [NO-1:0] core_out = '0, pin_out;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture(capture),
    .shift(shift), .update(update), .tdi(tdi), .tdo(tdo),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic s, logic u, logic d);
    capture = c; shift = s; update = u; tdi = d;
    @(negedge clk);
    capture = 0; shift = 0; update = 0;
  endtask

  // Loads pattern p into the update latches via shift then update.
  task automatic load(logic [N-1:0] p);
    for (int k = 0; k < N; k++) step(0, 1, 0, p[k]);
    step(0, 0, 1, 0);
  endtask

  task automatic t_reset();
    test_mode = 1;
    #1;
    check("R7 pin_out", pin_out, 0);
    check("R7 core_in", core_in, 0);
    check("R7 tdo", tdo, 0);
    @(negedge clk); rst_n = 1; test_mode = 0;
    @(negedge clk);
  endtask

  task automatic t_normal();
    test_mode = 0;
    pin_in = 4'hA; core_out = 4'h3; #1;
    check("R1 core_in", core_in, 4'hA);
    check("R1 pin_out", pin_out, 4'h3);
    pin_in = 4'h5; core_out = 4'hC; #1;
    check("R1 core_in b", core_in, 4'h5);
    check("R1 pin_out b", pin_out, 4'hC);
  endtask

  task automatic t_capture_shift();
    logic [N-1:0] cap, pat, got;
    pin_in = 4'h6; core_out = 4'h9; cap = {4'h9, 4'h6}; pat = 8'hB4;
    step(1, 0, 0, 0);
    check("R3 tdo after capture", tdo, cap[0]);
    for (int k = 0; k < N; k++) begin
      got[k] = tdo;
      step(0, 1, 0, pat[k]);
    end
    check("R5 serial out order", got, cap);
    got = '0;
    for (int k = 0; k < N; k++) begin
      got[k] = tdo;
      step(0, 1, 0, 0);
    end
    check("R4 tdi path after N shifts", got, pat);
  endtask

  task automatic t_update_hold();
    logic [N-1:0] p1 = 8'h5A, p2 = 8'hC3;
    test_mode = 1;
    load(p1);
    check("R2 pin_out", pin_out, p1[N-1:NI]);
    check("R2 core_in", core_in, p1[NI-1:0]);
    pin_in = 4'hF; core_out = 4'h0;
    step(1, 0, 0, 0);
    for (int k = 0; k < N; k++) begin
      step(0, 1, 0, p2[k]);
      check("R6 pin_out steady while shifting", pin_out, p1[N-1:NI]);
      check("R6 core_in steady while shifting", core_in, p1[NI-1:0]);
    end
    step(0, 0, 1, 0);
    check("R6 pin_out after update", pin_out, p2[N-1:NI]);
    check("R6 core_in after update", core_in, p2[NI-1:0]);
    test_mode = 0; #1;
    check("R1 transparent over latches", pin_out, core_out);
  endtask

  task automatic t_priority_idle();
    logic [N-1:0] got;
    pin_in = 4'h1; core_out = 4'h8;
    step(1, 1, 0, 1);
    check("R8 capture wins tdo", tdo, 1);
    step(0, 1, 0, 0);
    check("R8 next bit is captured", tdo, 0);
    step(1, 0, 0, 0);
    pin_in = 4'h0; core_out = 4'h0;
    for (int k = 0; k < 5; k++) step(0, 0, 0, 1);
    got = '0;
    for (int k = 0; k < N; k++) begin
      got[k] = tdo;
      step(0, 1, 0, 0);
    end
    check("R9 idle holds stages", got, {4'h8, 4'h1});
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_normal();
    t_capture_shift();
    t_update_hold();
    t_priority_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule